// File: doc/BRIEF.md
# Packed Sub-Element Reduction Unit

This unit takes one SEW-bit vector element and treats it as a short vector of equal, narrower sub-elements. A two-bit division code sets how many sub-elements there are. The unit reduces those sub-elements, together with a scalar seed taken from the low bits of a second operand, to a single value. That value is written to the low bits of the destination element and then extended to the full element width.

The supported reductions are:

- a widening sum,
- maximum and minimum,
- bitwise AND, OR and XOR,
- the ordinary single-width sum, which is legal only when the element is not divided.

Each reduction can be signed or unsigned. An element-enable bit covers the whole element. A disabled element, or an operation that is reserved for the chosen division, returns the prior destination value unchanged.

The unit accepts one element per cycle and presents the result one clock later. A vector sequencer outside this block steps through the elements and supplies the prior destination contents.

Top module: `subred_unit`

## Requirements
- R1: The division code `div_code` selects EDIV: 0→1, 1→2, 2→4, 3→8. Sub-element i occupies bits [i*SEW/EDIV +: SEW/EDIV] of `src`.
- R2: Max (`op`=2) and min (`op`=3) return the extreme value among all sub-elements and `seed[N-1:0]`, where N = max(8, SEW/EDIV). The comparison is two's-complement when `is_signed`=1 and unsigned otherwise.
- R3: AND (`op`=4), OR (`op`=5) and XOR (`op`=6) combine `seed[N-1:0]` with every sub-element, each sub-element first extended to N bits by sign (`is_signed`=1) or by zero.
- R4: The widening sum (`op`=1) returns `seed[W-1:0]` plus all sub-elements, each extended to W bits, taken modulo 2^W, where W = max(8, min(SEW, 2*SEW/EDIV)).
- R5: The narrow result of R2 to R4 is extended to SEW bits, by sign when `is_signed`=1 and by zero otherwise.
- R6: The single-width sum (`op`=0) with `div_code`=0 returns `src + seed` modulo 2^SEW.
- R7: The single-width sum with `div_code`≠0, or `op`=7, raises `illegal` and leaves `dest` equal to `dest_old`.
- R8: When `elem_en`=0, `dest` equals `dest_old`. `illegal` still reports the operation's legality.
- R9: `out_valid` and all results appear exactly one clock after `in_valid`. When `in_valid`=0, `dest` holds its value and `illegal` is 0.
- R10: While `rst_n` is low, `out_valid`, `illegal` and `dest` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | An element is presented this cycle |
| op | input | 3 | Reduction kind: 0 single sum, 1 widening sum, 2 max, 3 min, 4 and, 5 or, 6 xor, 7 reserved |
| div_code | input | 2 | Sub-element division code |
| is_signed | input | 1 | Two's-complement interpretation and sign extension |
| elem_en | input | 1 | Whole-element enable (mask bit) |
| src | input | SEW | Packed source element |
| seed | input | SEW | Scalar seed operand; its low bits are used |
| dest_old | input | SEW | Prior destination element |
| out_valid | output | 1 | Result valid |
| illegal | output | 1 | Reserved operation for this division |
| dest | output | SEW | Destination element |

## Verification
A reserved operation and a disabled element can arrive in the same cycle. Both force the destination back to its prior value, so the legality flag is the only output that tells the two cases apart. Directed vectors place a reserved single-width sum on a disabled element. The random stream also draws the mask and the opcode independently, which produces the overlap many times. The output is judged by requiring `dest` to equal `dest_old` while `illegal` is still raised.

// File: rtl/subred_pkg.sv
package subred_pkg;

  typedef enum logic [2:0] {
    OP_SUM  = 3'd0,
    OP_WSUM = 3'd1,
    OP_MAX  = 3'd2,
    OP_MIN  = 3'd3,
    OP_AND  = 3'd4,
    OP_OR   = 3'd5,
    OP_XOR  = 3'd6,
    OP_RSV  = 3'd7
  } red_op_e;

  // width of the non-sum result for a given element width and division code
  function automatic int unsigned nonsum_bits(int unsigned sew, logic [1:0] code);
    int unsigned sw;
    sw = sew >> code;
    return (sw < 8) ? 8 : sw;
  endfunction

  // width of the widening-sum result
  function automatic int unsigned wsum_bits(int unsigned sew, logic [1:0] code);
    int unsigned w;
    w = (sew >> code) * 2;
    if (w > sew) w = sew;
    if (w < 8) w = 8;
    return w;
  endfunction

endpackage

// File: rtl/subred_lane.sv
// Reduction datapath for one fixed division factor (EDIV = 2**DIVL).
module subred_lane
  import subred_pkg::*;
#(
  parameter int SEW  = 32,
  parameter int DIVL = 0
) (
  input  logic [SEW-1:0] src,
  input  logic [SEW-1:0] seed,
  input  red_op_e        op,
  input  logic           is_signed,
  output logic [SEW-1:0] res
);

  localparam int EDIV = 1 << DIVL;
  localparam int SW   = SEW / EDIV;
  localparam int NW   = (SW < 8) ? 8 : SW;
  localparam int WWC  = (2 * SW > SEW) ? SEW : 2 * SW;
  localparam int WW   = (WWC < 8) ? 8 : WWC;

  logic [EDIV-1:0][NW-1:0] sub_n;
  logic [EDIV-1:0][WW-1:0] sub_w;

  // R1: slice and extend each packed sub-element
  for (genvar i = 0; i < EDIV; i++) begin : g_sub
    logic [SW-1:0] raw;
    assign raw = src[i*SW +: SW];
    assign sub_n[i] = is_signed ? NW'($signed(raw)) : NW'(raw);
    assign sub_w[i] = is_signed ? WW'($signed(raw)) : WW'(raw);
  end

  logic [NW-1:0] flip;
  logic [NW-1:0] acc_max, acc_min, acc_and, acc_or, acc_xor;
  logic [WW-1:0] acc_sum;

  assign flip = NW'(is_signed) << (NW - 1);

  // linear reduction chain over the sub-elements
  always_comb begin
    acc_max = seed[NW-1:0];
    acc_min = seed[NW-1:0];
    acc_and = seed[NW-1:0];
    acc_or  = seed[NW-1:0];
    acc_xor = seed[NW-1:0];
    acc_sum = seed[WW-1:0];
    for (int i = 0; i < EDIV; i++) begin
      if ((sub_n[i] ^ flip) > (acc_max ^ flip)) acc_max = sub_n[i];
      if ((sub_n[i] ^ flip) < (acc_min ^ flip)) acc_min = sub_n[i];
      acc_and = acc_and & sub_n[i];
      acc_or  = acc_or  | sub_n[i];
      acc_xor = acc_xor ^ sub_n[i];
      acc_sum = acc_sum + sub_w[i];
    end
  end

  logic [NW-1:0] narrow;

  always_comb begin
    unique case (op)
      OP_MAX:  narrow = acc_max;
      OP_MIN:  narrow = acc_min;
      OP_AND:  narrow = acc_and;
      OP_OR:   narrow = acc_or;
      default: narrow = acc_xor;
    endcase
  end

  // R5: extension of the significant bits to the element width
  always_comb begin
    unique case (op)
      OP_SUM:  res = src + seed;
      OP_WSUM: res = is_signed ? SEW'($signed(acc_sum)) : SEW'(acc_sum);
      default: res = is_signed ? SEW'($signed(narrow)) : SEW'(narrow);
    endcase
  end

endmodule

// File: rtl/subred_writeback.sv
// Legality decode and destination selection.
module subred_writeback
  import subred_pkg::*;
#(
  parameter int SEW = 32
) (
  input  red_op_e        op,
  input  logic [1:0]     div_code,
  input  logic           elem_en,
  input  logic [SEW-1:0] lane_res,
  input  logic [SEW-1:0] dest_old,
  output logic           illegal_c,
  output logic [SEW-1:0] dest_d
);

  always_comb begin
    illegal_c = (op == OP_RSV) || ((op == OP_SUM) && (div_code != 2'd0));
    dest_d    = (elem_en && !illegal_c) ? lane_res : dest_old;
  end

endmodule

// File: rtl/subred_unit.sv
module subred_unit
  import subred_pkg::*;
#(
  parameter int SEW = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  input  logic [2:0]     op,
  input  logic [1:0]     div_code,
  input  logic           is_signed,
  input  logic           elem_en,
  input  logic [SEW-1:0] src,
  input  logic [SEW-1:0] seed,
  input  logic [SEW-1:0] dest_old,
  output logic           out_valid,
  output logic           illegal,
  output logic [SEW-1:0] dest
);

  localparam int NDIV = 4;

  red_op_e op_e;
  assign op_e = red_op_e'(op);

  logic [NDIV-1:0][SEW-1:0] lane_res;

  for (genvar k = 0; k < NDIV; k++) begin : g_lane
    subred_lane #(.SEW(SEW), .DIVL(k)) u_lane (
      .src       (src),
      .seed      (seed),
      .op        (op_e),
      .is_signed (is_signed),
      .res       (lane_res[k])
    );
  end

  logic           illegal_c;
  logic [SEW-1:0] dest_d;

  subred_writeback #(.SEW(SEW)) u_wb (
    .op        (op_e),
    .div_code  (div_code),
    .elem_en   (elem_en),
    .lane_res  (lane_res[div_code]),
    .dest_old  (dest_old),
    .illegal_c (illegal_c),
    .dest_d    (dest_d)
  );

  // next-state
  logic           valid_d, illegal_d;
  logic [SEW-1:0] dest_q;
  logic           valid_q, illegal_q;

  always_comb begin
    valid_d   = in_valid;
    illegal_d = in_valid & illegal_c;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q   <= 1'b0;
      illegal_q <= 1'b0;
      dest_q    <= '0;
    end else begin
      valid_q   <= valid_d;
      illegal_q <= illegal_d;
      if (in_valid) dest_q <= dest_d;
    end
  end

  assign out_valid = valid_q;
  assign illegal   = illegal_q;
  assign dest      = dest_q;

  int unsigned nw_bits;
  assign nw_bits = nonsum_bits(SEW, div_code);

  p_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !illegal && $stable(dest));

  p_reserved_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (op == 3'd0) && (div_code != 2'd0) |=> illegal && dest == $past(dest_old));

  p_mask_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !elem_en |=> dest == $past(dest_old));

  p_zero_ext_r5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && elem_en && !is_signed && (op >= 3'd2) && (op <= 3'd6)
    |=> (dest >> $past(nw_bits)) == '0);

endmodule

// File: tb/subred_unit_test.sv
module subred_unit_test;

  localparam int SEW = 32;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           in_valid;
  logic [2:0]     op;
  logic [1:0]     div_code;
  logic           is_signed;
  logic           elem_en;
  logic [SEW-1:0] src, seed, dest_old;
  logic           out_valid, illegal;
  logic [SEW-1:0] dest;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  subred_unit #(.SEW(SEW)) uut (
    .clk, .rst_n, .in_valid, .op, .div_code, .is_signed, .elem_en,
    .src, .seed, .dest_old, .out_valid, .illegal, .dest
  );

  function automatic longint val_of(logic [31:0] x, int w, bit sg);
    longint u;
    u = longint'({32'd0, x}) & ((64'sd1 <<< w) - 1);
    if (sg && u[w-1]) u = u - (64'sd1 <<< w);
    return u;
  endfunction

  function automatic logic [31:0] model(logic [2:0] o, logic [1:0] c, bit sg, bit en,
                                        logic [31:0] s, logic [31:0] sd, logic [31:0] old,
                                        output bit ill);
    int ed, sw, nw, ww;
    longint acc, v;
    ed = 1 << c;
    sw = 32 / ed;
    nw = (sw < 8) ? 8 : sw;
    ww = (2 * sw > 32) ? 32 : 2 * sw;
    if (ww < 8) ww = 8;
    ill = (o == 3'd7) || (o == 3'd0 && c != 2'd0);
    if (ill || !en) return old;
    if (o == 3'd0) return s + sd;
    acc = val_of(sd, (o == 3'd1) ? ww : nw, sg);
    for (int i = 0; i < ed; i++) begin
      v = val_of(s >> (i * sw), sw, sg);
      case (o)
        3'd1: acc = acc + v;
        3'd2: if (v > acc) acc = v;
        3'd3: if (v < acc) acc = v;
        3'd4: acc = acc & v;
        3'd5: acc = acc | v;
        default: acc = acc ^ v;
      endcase
    end
    if (o == 3'd1) acc = val_of(acc[31:0], ww, sg);
    return acc[31:0];
  endfunction

  function automatic string tag_of(logic [2:0] o, logic [1:0] c, bit en);
    if (o == 3'd7 || (o == 3'd0 && c != 2'd0)) return "R7";
    if (!en) return "R8";
    case (o)
      3'd0: return "R6";
      3'd1: return "R4";
      3'd2, 3'd3: return "R2";
      default: return "R3";
    endcase
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // apply one element, wait one clock, check all outputs
  task automatic step(logic [2:0] o, logic [1:0] c, bit sg, bit en,
                      logic [31:0] s, logic [31:0] sd, logic [31:0] old,
                      string tag, bit use_lit, logic [31:0] lit);
    bit ill;
    logic [31:0] exp;
    exp = model(o, c, sg, en, s, sd, old, ill);
    if (use_lit) exp = lit;
    in_valid = 1'b1; op = o; div_code = c; is_signed = sg; elem_en = en;
    src = s; seed = sd; dest_old = old;
    @(negedge clk);
    check({tag, " valid R9"}, {31'd0, out_valid}, 32'd1);
    check({tag, " illegal"}, {31'd0, illegal}, {31'd0, ill});
    check(tag, dest, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; in_valid = 1'b0; op = '0; div_code = '0; is_signed = 1'b0;
    elem_en = 1'b1; src = '0; seed = '0; dest_old = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10 valid", {31'd0, out_valid}, 32'd0);
    check("R10 illegal", {31'd0, illegal}, 32'd0);
    check("R10 dest", dest, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: byte widening sum, unsigned
    step(3'd1, 2'd2, 1'b0, 1'b1, 32'h01020304, 32'h00000010, 32'h0, "R4", 1'b1, 32'h0000001A);
    // R4: EDIV=8 nibble sum wraps in 8 bits
    step(3'd1, 2'd3, 1'b0, 1'b1, 32'hFFFFFFFF, 32'h000000F0, 32'h0, "R4", 1'b1, 32'h00000068);
    // R2: signed max vs unsigned max
    step(3'd2, 2'd2, 1'b1, 1'b1, 32'hFF800102, 32'h00000080, 32'h0, "R2", 1'b1, 32'h00000002);
    step(3'd2, 2'd2, 1'b0, 1'b1, 32'hFF800102, 32'h00000080, 32'h0, "R2", 1'b1, 32'h000000FF);
    // R5: signed min sign-extends
    step(3'd3, 2'd2, 1'b1, 1'b1, 32'hFF800102, 32'h00000000, 32'h0, "R5", 1'b1, 32'hFFFFFF80);
    // R1: halves of the element
    step(3'd2, 2'd1, 1'b0, 1'b1, 32'h12345678, 32'h00000000, 32'h0, "R1", 1'b1, 32'h00005678);
    // R3: nibble xor with sign extension
    step(3'd6, 2'd3, 1'b1, 1'b1, 32'h0000000F, 32'h00000000, 32'h0, "R3", 1'b1, 32'hFFFFFFFF);
    // R6: undivided single-width sum wraps
    step(3'd0, 2'd0, 1'b0, 1'b1, 32'hFFFFFFFF, 32'h00000002, 32'h0, "R6", 1'b1, 32'h00000001);
    // R7: reserved single-width sum, reserved opcode
    step(3'd0, 2'd1, 1'b0, 1'b1, 32'h11111111, 32'h1, 32'hDEADBEEF, "R7", 1'b1, 32'hDEADBEEF);
    step(3'd7, 2'd0, 1'b1, 1'b1, 32'h11111111, 32'h1, 32'hCAFEF00D, "R7", 1'b1, 32'hCAFEF00D);
    // R8 with R7 in the same cycle
    step(3'd0, 2'd2, 1'b0, 1'b0, 32'h11111111, 32'h1, 32'hA5A5A5A5, "R8", 1'b1, 32'hA5A5A5A5);
    step(3'd1, 2'd2, 1'b0, 1'b0, 32'h01020304, 32'h0, 32'h5A5A5A5A, "R8", 1'b1, 32'h5A5A5A5A);

    // R9: idle holds the last result
    held = dest;
    in_valid = 1'b0; src = 32'h87654321; dest_old = 32'h0; op = 3'd1;
    @(negedge clk);
    check("R9 idle valid", {31'd0, out_valid}, 32'd0);
    check("R9 idle illegal", {31'd0, illegal}, 32'd0);
    check("R9 idle dest", dest, held);

    for (int n = 0; n < 3000; n++) begin
      logic [2:0] o;
      logic [1:0] c;
      bit en;
      o  = 3'($urandom_range(0, 7));
      c  = 2'($urandom_range(0, 3));
      en = ($urandom_range(0, 9) != 0);
      step(o, c, 1'($urandom()), en, $urandom(), $urandom(), $urandom(),
           tag_of(o, c, en), 1'b0, 32'h0);
    end

    in_valid = 1'b0;
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule